// File: doc/BRIEF.md
# Register-Driven Flash Command Sequencer

This block lets software run flash operations by writing a small register set: an address register, four 32-bit data lanes that together form one 128-bit flash word, and a control register whose low three bits carry a command code. A legal command written to the control register is queued. The sequencer then offers it to the flash macro over a request/grant port, follows it until the macro reports completion, and records the outcome in a status register and in one-cycle event pulses.

Before a command is queued, the sequencer checks that the code is legal, that the address is aligned for the kind of access, that no earlier command is still waiting, and that the issuing domain may command the flash. When the macro grants a command, the control field returns to zero. Software can then preload the next row-write word while the current one is still programming. If that next row write is queued in time, it follows with no gap. If it is not, the sequencer sends an idle command to the macro to close the row-write sequence.

The flash macro is modelled as a request/grant handshake followed by a done strobe, with an error line that can be raised during the run. Software reaches the registers through a plain indexed write strobe and a combinational read port.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write of a legal nonzero code to the control register (index 0, bits [2:0]) queues it, and the control register reads that code until the flash grants it. At the grant the field reads 0, status bit 1 (accepted) is set, and `evt_accept` pulses for one cycle.
- R2: The status register (index 1) has pending in bit 0, accepted in bit 1, success in bit 2, fail in bit 3, finished in bit 4 and port-held in bit 5. Bits [31:6] read 0. The other indices are: 2 for address, 4 to 7 for data lanes 0 to 3, and 3 reads 0. The reset value of every register is 0.
- R3: The command codes are 1 read, 2 write, 3 row write, 4 sector erase and 5 mass erase. Writing code 0 has no effect. Codes 6 and 7 pulse `evt_reject` and are never sent to the flash.
- R4: A write or row write needs address bits [1:0] equal to 0, and a read needs address bits [3:0] equal to 0. A misaligned command pulses `evt_reject` and is not sent.
- R5: A control write with a nonzero code while the control field is nonzero is ignored: the queued code is kept and `evt_reject` pulses.
- R6: A control write from the secondary domain (`reg_secondary`=1) while `cfg_mode`=1 pulses `evt_fail`. It is not sent to the flash and leaves the status register unchanged.
- R7: `fl_req` stays high with a stable `fl_cmd` and `fl_addr` until `fl_gnt` is seen.
- R8: On `fl_done` for a running command, finished is set. Success and `evt_success` result if `fl_err` was not seen since the grant; otherwise fail and `evt_fail` result. Pending clears if nothing else is queued. Success, fail and finished clear at the next grant.
- R9: A read that completes without error loads the 128-bit `fl_rdata` into the data lanes. Lane 0 holds bits [31:0] and lane 3 holds bits [127:96].
- R10: If a row write is queued at least one cycle before a running row write completes, it is offered next, with no idle command between the two.
- R11: Otherwise, after a row write completes, the idle code 0 is offered on the flash port with the same handshake, and no completion is awaited, before any later command.
- R12: `fl_addr` is the address register, and `fl_wdata` is the four data lanes with lane 0 in bits [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for the write |
| reg_wdata | input | 32 | Register write data |
| reg_secondary | input | 1 | The write comes from the secondary domain |
| cfg_mode | input | 1 | Partition configuration mode is active |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 32 | Read data (combinational) |
| fl_req | output | 1 | Command offered to the flash |
| fl_cmd | output | 3 | Command code offered |
| fl_addr | output | 22 | Flash byte address |
| fl_wdata | output | 128 | Flash write word |
| fl_gnt | input | 1 | Flash takes the offered command |
| fl_done | input | 1 | Running command finished |
| fl_err | input | 1 | Error on the running command |
| fl_rdata | input | 128 | Flash read word, valid with done |
| evt_accept | output | 1 | Command granted pulse |
| evt_success | output | 1 | Command succeeded pulse |
| evt_fail | output | 1 | Command failed or domain refused pulse |
| evt_reject | output | 1 | Command rejected pulse |

## Verification
On every cycle, the assertions check the grant behaviour: the control field is cleared with the accepted flag and its pulse. They also check that a request holds until it is granted, that a control write to a busy queue always rejects, that the upper status bits stay zero, and that each completion gives exactly one of success and fail along with finished. Other behaviours can only be shown by the bench's scenarios, because they depend on the order of events rather than on a single cycle. These include whether a row write follows back to back or gets an idle command between, the loading of read data into the correct lanes, and the screening of misaligned, illegal and refused commands so that nothing reaches the flash.

// File: rtl/fcs_pkg.sv
// Shared types and encodings for the flash command sequencer.
// Assumes: 3-bit command codes and 3-bit register indices, which software decodes.
package fcs_pkg;
    localparam int CMD_W = 3;
    localparam int IDX_W = 3;
    localparam int STAT_W = 6;

    typedef logic [CMD_W-1:0] fcmd_t;
    localparam fcmd_t FC_IDLE  = 3'd0;
    localparam fcmd_t FC_READ  = 3'd1;
    localparam fcmd_t FC_WRITE = 3'd2;
    localparam fcmd_t FC_ROW   = 3'd3;
    localparam fcmd_t FC_ERASE = 3'd4;
    localparam fcmd_t FC_MASS  = 3'd5;

    typedef logic [IDX_W-1:0] ridx_t;
    localparam ridx_t RI_CTRL  = 3'd0;
    localparam ridx_t RI_STAT  = 3'd1;
    localparam ridx_t RI_ADDR  = 3'd2;
    localparam ridx_t RI_DATA0 = 3'd4;

    typedef enum logic [1:0] {VD_NONE, VD_QUEUE, VD_REJECT, VD_DENY} verdict_t;

    // The first field is the MSB: held is bit 5 and pending is bit 0.
    typedef struct packed {
        logic held;
        logic finished;
        logic fail;
        logic success;
        logic accepted;
        logic pending;
    } status_t;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RUN, ST_GAP} eng_state_t;
endpackage

// File: rtl/fcs_cmd_check.sv
// Screens a control-register write before it is queued.
// Assumes: the address alignment follows the lane width (writes) and the word width (reads).
// Priority order: busy queue, refused domain, illegal code, misalignment.
module fcs_cmd_check
    import fcs_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_DATA = 4,
    localparam int WR_AL   = $clog2(DATA_W / 8),
    localparam int RD_AL   = $clog2(NUM_DATA * DATA_W / 8)
) (
    input  fcmd_t            code,
    input  logic [RD_AL-1:0] addr_lo,
    input  logic             queue_busy,
    input  logic             from_secondary,
    input  logic             cfg_mode,
    output verdict_t         verdict
);
    logic legal, wr_mis, rd_mis;

    // Classify the code and the alignment of the address.
    always_comb begin
        legal  = (code == FC_READ) || (code == FC_WRITE) || (code == FC_ROW) ||
                 (code == FC_ERASE) || (code == FC_MASS);
        wr_mis = ((code == FC_WRITE) || (code == FC_ROW)) && (|addr_lo[WR_AL-1:0]);
        rd_mis = (code == FC_READ) && (|addr_lo);
    end

    // Combine the checks in priority order.
    always_comb begin
        if (code == FC_IDLE)              verdict = VD_NONE;
        else if (queue_busy)              verdict = VD_REJECT;
        else if (from_secondary && cfg_mode) verdict = VD_DENY;
        else if (!legal || wr_mis || rd_mis) verdict = VD_REJECT;
        else                              verdict = VD_QUEUE;
    end
endmodule

// File: rtl/fcs_regbank.sv
// Holds the address register and the data lanes, and drives the read port.
// Assumes: ADDR_W < DATA_W, NUM_DATA <= 4, and read-data capture wins over a software write.
module fcs_regbank
    import fcs_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 32,
    parameter int NUM_DATA = 4,
    localparam int WORD_W  = NUM_DATA * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  ridx_t             reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              cap_rd,
    input  logic [WORD_W-1:0] fl_rdata,
    input  ridx_t             rd_idx,
    input  fcmd_t             cmd_q,
    input  status_t           stat,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] word_q
);
    logic [DATA_W-1:0] lane [NUM_DATA];

    // Address register, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)                              addr_q <= '0;
        else if (reg_wr && reg_idx == RI_ADDR)   addr_q <= reg_wdata[ADDR_W-1:0];
    end

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_lane
        logic [DATA_W-1:0] lane_q;
        // One data lane: flash read capture first, then the software write.
        always_ff @(posedge clk) begin
            if (!rst_n)      lane_q <= '0;
            else if (cap_rd) lane_q <= fl_rdata[g*DATA_W +: DATA_W];
            else if (reg_wr && reg_idx == IDX_W'(RI_DATA0 + g)) lane_q <= reg_wdata;
        end
        assign lane[g] = lane_q;
        assign word_q[g*DATA_W +: DATA_W] = lane_q;
    end

    // Read multiplexer; unused indices and bits read as zero.
    always_comb begin
        rd_data = '0;
        if (rd_idx == RI_CTRL)      rd_data = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
        else if (rd_idx == RI_STAT) rd_data = {{(DATA_W-STAT_W){1'b0}}, stat};
        else if (rd_idx == RI_ADDR) rd_data = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
        for (int i = 0; i < NUM_DATA; i++)
            if (rd_idx == IDX_W'(RI_DATA0 + i)) rd_data = lane[i];
    end
endmodule

// File: rtl/fcs_engine.sv
// Command queue, flash handshake, completion tracking and status flags.
// Assumes: the flash samples address and data at the grant; fl_err counts only while running;
// the choice between back-to-back and idle insertion uses the queue as registered before done.
module fcs_engine
    import fcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  fcmd_t    code,
    input  verdict_t verdict,
    input  logic     fl_gnt,
    input  logic     fl_done,
    input  logic     fl_err,
    output fcmd_t    cmd_q,
    output status_t  stat,
    output logic     fl_req,
    output fcmd_t    fl_cmd,
    output logic     cap_rd,
    output logic     running,
    output logic     evt_accept,
    output logic     evt_success,
    output logic     evt_fail,
    output logic     evt_reject
);
    eng_state_t state;
    fcmd_t      run_cmd;
    logic       err_seen, accepted, success, fail, finished;
    logic       err_now;

    assign err_now = err_seen | fl_err;
    assign running = (state == ST_RUN);
    assign fl_req  = (state == ST_REQ) || (state == ST_GAP);
    assign fl_cmd  = (state == ST_REQ) ? cmd_q : FC_IDLE;
    assign cap_rd  = running && fl_done && (run_cmd == FC_READ) && !err_now;

    // Assemble the status word from the state and the sticky flags.
    always_comb begin
        stat.pending  = (cmd_q != FC_IDLE) || running;
        stat.accepted = accepted;
        stat.success  = success;
        stat.fail     = fail;
        stat.finished = finished;
        stat.held     = running || (state == ST_GAP);
    end

    // Queue intake, sequencing and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  cmd_q <= FC_IDLE;  run_cmd <= FC_IDLE;
            err_seen <= 1'b0;  accepted <= 1'b0;  success <= 1'b0;
            fail <= 1'b0;      finished <= 1'b0;
            evt_accept <= 1'b0; evt_success <= 1'b0; evt_fail <= 1'b0; evt_reject <= 1'b0;
        end else begin
            evt_accept <= 1'b0; evt_success <= 1'b0; evt_fail <= 1'b0; evt_reject <= 1'b0;
            if (ctrl_wr) begin
                case (verdict)
                    VD_QUEUE:  begin cmd_q <= code; accepted <= 1'b0; end
                    VD_REJECT: evt_reject <= 1'b1;
                    VD_DENY:   evt_fail <= 1'b1;
                    default:   ;
                endcase
            end
            case (state)
                ST_IDLE: if (cmd_q != FC_IDLE) state <= ST_REQ;
                ST_REQ: if (fl_gnt) begin
                    cmd_q <= FC_IDLE;  run_cmd <= cmd_q;
                    accepted <= 1'b1;  evt_accept <= 1'b1;
                    success <= 1'b0;   fail <= 1'b0;  finished <= 1'b0;
                    err_seen <= 1'b0;  state <= ST_RUN;
                end
                ST_RUN: begin
                    if (fl_err) err_seen <= 1'b1;
                    if (fl_done) begin
                        finished <= 1'b1;
                        if (err_now) begin fail <= 1'b1; evt_fail <= 1'b1; end
                        else begin success <= 1'b1; evt_success <= 1'b1; end
                        if (run_cmd == FC_ROW && cmd_q != FC_ROW) state <= ST_GAP;
                        else if (cmd_q != FC_IDLE)                state <= ST_REQ;
                        else                                      state <= ST_IDLE;
                    end
                end
                ST_GAP: if (fl_gnt) state <= (cmd_q != FC_IDLE) ? ST_REQ : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the register-driven flash command sequencer.
// Assumes: a single clock, synchronous active-low reset, one register write per cycle.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 32,
    parameter int NUM_DATA = 4,
    localparam int WORD_W  = NUM_DATA * DATA_W,
    localparam int RD_AL   = $clog2(WORD_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_secondary,
    input  logic              cfg_mode,
    input  logic [2:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              fl_req,
    output logic [2:0]        fl_cmd,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [WORD_W-1:0] fl_wdata,
    input  logic              fl_gnt,
    input  logic              fl_done,
    input  logic              fl_err,
    input  logic [WORD_W-1:0] fl_rdata,
    output logic              evt_accept,
    output logic              evt_success,
    output logic              evt_fail,
    output logic              evt_reject
);
    fcmd_t    cmd_q;
    status_t  stat;
    verdict_t verdict;
    logic     ctrl_wr, cap_rd, eng_running;
    logic [STAT_W-1:0] stat_bits;

    assign ctrl_wr   = reg_wr && (reg_idx == RI_CTRL) && (reg_wdata[CMD_W-1:0] != FC_IDLE);
    assign stat_bits = stat;

    fcs_cmd_check #(.DATA_W(DATA_W), .NUM_DATA(NUM_DATA)) u_check (
        .code(reg_wdata[CMD_W-1:0]), .addr_lo(fl_addr[RD_AL-1:0]),
        .queue_busy(cmd_q != FC_IDLE), .from_secondary(reg_secondary),
        .cfg_mode(cfg_mode), .verdict(verdict)
    );

    fcs_engine u_engine (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .code(reg_wdata[CMD_W-1:0]),
        .verdict(verdict), .fl_gnt(fl_gnt), .fl_done(fl_done), .fl_err(fl_err),
        .cmd_q(cmd_q), .stat(stat), .fl_req(fl_req), .fl_cmd(fl_cmd),
        .cap_rd(cap_rd), .running(eng_running), .evt_accept(evt_accept),
        .evt_success(evt_success), .evt_fail(evt_fail), .evt_reject(evt_reject)
    );

    fcs_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DATA(NUM_DATA)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .cap_rd(cap_rd), .fl_rdata(fl_rdata),
        .rd_idx(rd_idx), .cmd_q(cmd_q), .stat(stat), .rd_data(rd_data),
        .addr_q(fl_addr), .word_q(fl_wdata)
    );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
// Cycle-level checks for the flash command sequencer, attached to the top by bind.
// Assumes: the indices and status bit positions documented in the package.
module flash_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_idx,
    input logic [2:0]  reg_code,
    input logic [2:0]  rd_idx,
    input logic [25:0] rd_hi,
    input logic        fl_req,
    input logic        fl_gnt,
    input logic [2:0]  fl_cmd,
    input logic        fl_done,
    input logic        evt_accept,
    input logic        evt_reject,
    input logic [2:0]  cmd_q,
    input logic [5:0]  stat,
    input logic        running
);
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_gnt && fl_cmd != 3'd0) |=> (cmd_q == 3'd0 && stat[1] && evt_accept)); // R1
    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 3'd1) |-> (rd_hi == '0)); // R2
    AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 3'd0 && reg_code != 3'd0 && cmd_q != 3'd0) |=> evt_reject); // R5
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_gnt) |=> (fl_req && $stable(fl_cmd))); // R7
    AST_DONE_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (running && fl_done) |=> (stat[4] && (stat[2] ^ stat[3]))); // R8
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_code(reg_wdata[2:0]), .rd_idx(rd_idx), .rd_hi(rd_data[31:6]),
    .fl_req(fl_req), .fl_gnt(fl_gnt), .fl_cmd(fl_cmd), .fl_done(fl_done),
    .evt_accept(evt_accept), .evt_reject(evt_reject), .cmd_q(cmd_q),
    .stat(stat_bits), .running(eng_running)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
    logic         clk = 1'b0, rst_n = 1'b0;
    logic         reg_wr = 1'b0, reg_secondary = 1'b0, cfg_mode = 1'b0;
    logic [2:0]   reg_idx = '0, rd_idx = '0;
    logic [31:0]  reg_wdata = '0, rd_data;
    logic         fl_req, fl_gnt = 1'b0, fl_done = 1'b0, fl_err = 1'b0;
    logic [2:0]   fl_cmd;
    logic [21:0]  fl_addr;
    logic [127:0] fl_wdata, fl_rdata = '0;
    logic         evt_accept, evt_success, evt_fail, evt_reject;

    int n_chk = 0, n_bad = 0;
    int n_acc = 0, n_succ = 0, n_fail = 0, n_rej = 0;
    int gnt_dly = 0, run_lat = 6;
    bit err_next = 1'b0;
    int log_n = 0;
    logic [2:0]   log_cmd [64];
    logic [21:0]  log_addr [64];
    logic [127:0] log_wd [64];

    flash_cmd_seq u_dut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [127:0] rdata_of(logic [21:0] a);
        logic [31:0] w = {10'd0, a};
        return {~w, w ^ 32'hC3C3_0F0F, w + 32'd7, w};
    endfunction

    // 0 none, 1 queued, 2 rejected, 3 refused domain (queue idle)
    function automatic int exp_v(int code, logic [21:0] a, bit sec, bit cfg);
        if (code == 0) return 0;
        if (sec && cfg) return 3;
        if (code > 5) return 2;
        if ((code == 2 || code == 3) && a[1:0] != 2'b0) return 2;
        if (code == 1 && a[3:0] != 4'b0) return 2;
        return 1;
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] idx, logic [31:0] d, bit sec = 0, bit cfg = 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d; reg_secondary = sec; cfg_mode = cfg;
        @(negedge clk);
        reg_wr = 1'b0; reg_secondary = 1'b0; cfg_mode = 1'b0;
    endtask

    task automatic rd(logic [2:0] idx, output logic [31:0] v);
        rd_idx = idx; #1; v = rd_data;
    endtask

    task automatic wait_end(int start);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (n_succ + n_fail > start) break;
        end
        check(n_succ + n_fail > start, "R8 completion seen", n_succ + n_fail, start + 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_acc(int start);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (n_acc > start) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // Count event pulses.
    always @(negedge clk) if (rst_n) begin
        if (evt_accept) n_acc++;
        if (evt_success) n_succ++;
        if (evt_fail) n_fail++;
        if (evt_reject) n_rej++;
    end

    // Flash macro model: grant after gnt_dly, finish after run_lat, optional two-cycle error.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && fl_req) begin
                automatic logic [2:0]  c0 = fl_cmd;
                automatic logic [21:0] a0 = fl_addr;
                repeat (gnt_dly) @(negedge clk);
                check(fl_req && fl_cmd == c0 && fl_addr == a0, "R7 request held", {fl_req, fl_cmd}, {1'b1, c0});
                log_cmd[log_n % 64] = c0; log_addr[log_n % 64] = a0; log_wd[log_n % 64] = fl_wdata;
                log_n++;
                fl_gnt = 1'b1;
                @(negedge clk);
                fl_gnt = 1'b0;
                if (c0 != 3'd0) begin
                    repeat (run_lat - 2) @(negedge clk);
                    if (err_next) fl_err = 1'b1;
                    @(negedge clk);
                    fl_done = 1'b1; fl_rdata = rdata_of(a0);
                    @(negedge clk);
                    fl_done = 1'b0; fl_err = 1'b0; err_next = 1'b0;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, s0;
        int s, c0, r0, f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2)
        rd(3'd1, v); check(v == 0, "R2 status reset", v, 0);
        rd(3'd0, v); check(v == 0, "R2 ctrl reset", v, 0);
        rd(3'd7, v); check(v == 0, "R2 lane3 reset", v, 0);
        check(fl_req == 0, "R2 no request at reset", fl_req, 0);

        // Read with readback while queued (R1, R5, R9, R8)
        gnt_dly = 8;
        wr(3'd2, 32'h100);
        c0 = n_succ + n_fail; r0 = n_rej;
        wr(3'd0, 32'd1);
        rd(3'd0, v); check(v == 1, "R1 ctrl shows queued code", v, 1);
        wr(3'd0, 32'd2);
        repeat (2) @(negedge clk);
        check(n_rej == r0 + 1, "R5 busy write rejected", n_rej, r0 + 1);
        rd(3'd0, v); check(v == 1, "R5 queued code kept", v, 1);
        wait_acc(n_acc - 0);
        rd(3'd0, v); check(v == 0, "R1 ctrl cleared at grant", v, 0);
        rd(3'd1, v); check(v[1] == 1, "R1 accepted flag", v, 2);
        wait_end(c0);
        rd(3'd1, v); check(v[5:0] == 6'b010110, "R8 status after success", v, 6'b010110);
        rd(3'd4, v); check(v == rdata_of(22'h100)[31:0], "R9 lane0", v, rdata_of(22'h100)[31:0]);
        rd(3'd7, v); check(v == rdata_of(22'h100)[127:96], "R9 lane3 upper bits", v, rdata_of(22'h100)[127:96]);
        check(log_cmd[(log_n-1)%64] == 3'd1 && log_addr[(log_n-1)%64] == 22'h100, "R12 read addr", log_addr[(log_n-1)%64], 22'h100);
        gnt_dly = 0;

        // Write data path (R12) and error outcome (R8)
        wr(3'd4, 32'h1111_0000); wr(3'd5, 32'h2222_0001); wr(3'd6, 32'h3333_0002); wr(3'd7, 32'h4444_0003);
        wr(3'd2, 32'h204);
        err_next = 1'b1; c0 = n_succ + n_fail; f0 = n_fail;
        wr(3'd0, 32'd2);
        wait_end(c0);
        check(log_wd[(log_n-1)%64] == 128'h4444_0003_3333_0002_2222_0001_1111_0000, "R12 write word",
              log_wd[(log_n-1)%64], 128'h4444_0003_3333_0002_2222_0001_1111_0000);
        check(n_fail == f0 + 1, "R8 error gives fail event", n_fail, f0 + 1);
        rd(3'd1, v); check(v[5:0] == 6'b011010, "R8 status after error", v, 6'b011010);

        // Misaligned and illegal codes (R3, R4)
        s = log_n; r0 = n_rej;
        wr(3'd2, 32'h102); wr(3'd0, 32'd2);
        wr(3'd2, 32'h108); wr(3'd0, 32'd1);
        wr(3'd2, 32'h100); wr(3'd0, 32'd6); wr(3'd0, 32'd7);
        repeat (4) @(negedge clk);
        check(n_rej == r0 + 4, "R4 R3 rejects counted", n_rej, r0 + 4);
        check(log_n == s, "R4 nothing forwarded", log_n, s);
        rd(3'd0, v); check(v == 0, "R3 code 0 no effect", v, 0);

        // Refused domain (R6)
        rd(3'd1, s0); s = log_n; f0 = n_fail;
        wr(3'd0, 32'd4, 1, 1);
        repeat (4) @(negedge clk);
        check(n_fail == f0 + 1, "R6 refused fail event", n_fail, f0 + 1);
        check(log_n == s, "R6 not forwarded", log_n, s);
        rd(3'd1, v); check(v == s0, "R6 status unchanged", v, s0);
        c0 = n_succ + n_fail;
        wr(3'd0, 32'd4, 1, 0);
        wait_end(c0);
        check(log_cmd[(log_n-1)%64] == 3'd4, "R6 secondary outside config allowed", log_cmd[(log_n-1)%64], 4);

        // Back-to-back row writes (R10, R11)
        run_lat = 30; s = log_n; c0 = n_succ + n_fail;
        wr(3'd2, 32'h40); wr(3'd4, 32'hA0); wr(3'd0, 32'd3);
        wait_acc(n_acc);
        wr(3'd2, 32'h44); wr(3'd4, 32'hA1); wr(3'd0, 32'd3);
        wait_end(c0); wait_end(c0 + 1);
        repeat (4) @(negedge clk);
        check(log_n == s + 3, "R10 three port commands", log_n, s + 3);
        check(log_cmd[s%64] == 3 && log_cmd[(s+1)%64] == 3, "R10 no idle between rows",
              {log_cmd[s%64], log_cmd[(s+1)%64]}, 6'o33);
        check(log_addr[(s+1)%64] == 22'h44 && log_wd[(s+1)%64][31:0] == 32'hA1, "R12 preloaded word",
              log_wd[(s+1)%64][31:0], 32'hA1);
        check(log_cmd[(s+2)%64] == 0, "R11 idle after last row", log_cmd[(s+2)%64], 0);

        // Late preload (R11)
        run_lat = 8; s = log_n; c0 = n_succ + n_fail;
        wr(3'd2, 32'h80); wr(3'd0, 32'd3);
        wait_end(c0);
        wr(3'd2, 32'h84); wr(3'd0, 32'd3);
        wait_end(c0 + 1);
        repeat (4) @(negedge clk);
        check(log_n == s + 4 && log_cmd[(s+1)%64] == 0 && log_cmd[(s+2)%64] == 3 && log_cmd[(s+3)%64] == 0,
              "R11 idle inserted when late", {log_cmd[(s+1)%64], log_cmd[(s+2)%64], log_cmd[(s+3)%64]}, 9'o030);

        // Constrained random commands
        void'($urandom(32'd4242));
        run_lat = 5;
        for (int it = 0; it < 40; it++) begin
            automatic int pick = $urandom % 6;
            automatic int code = (pick < 2) ? pick + 1 : pick + 2;
            automatic logic [21:0] a = 22'($urandom);
            automatic bit sec = $urandom % 2;
            automatic bit cfg = ($urandom % 3) == 0;
            automatic bit e = ($urandom % 4) == 0;
            automatic int ev;
            if ($urandom % 2) a[3:0] = 4'b0;
            ev = exp_v(code, a, sec, cfg);
            s = log_n; c0 = n_succ + n_fail; r0 = n_rej; f0 = n_fail;
            err_next = e;
            wr(3'd2, {10'd0, a});
            wr(3'd0, code, sec, cfg);
            if (ev == 1) begin
                wait_end(c0);
                check(log_cmd[(log_n-1)%64] == code && log_addr[(log_n-1)%64] == a, "R3 R4 forwarded command",
                      {log_cmd[(log_n-1)%64], log_addr[(log_n-1)%64]}, {code[2:0], a});
                rd(3'd1, v);
                check(v[5:0] == (e ? 6'b011010 : 6'b010110), "R8 random outcome", v, e ? 6'b011010 : 6'b010110);
                if (code == 1 && !e) begin
                    rd(3'd6, v); check(v == rdata_of(a)[95:64], "R9 random lane2", v, rdata_of(a)[95:64]);
                end
            end else begin
                repeat (4) @(negedge clk);
                err_next = 1'b0;
                check(log_n == s, "R4 R6 not forwarded", log_n, s);
                if (ev == 2) check(n_rej == r0 + 1, "R3 R4 random reject", n_rej, r0 + 1);
                else         check(n_fail == f0 + 1, "R6 random refusal", n_fail, f0 + 1);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule